// File: doc/BRIEF.md
# Value-Extended Register File with Steering Tags

This block is a physical register file for an out-of-order core. Each register entry has a full-width data word and a narrow side slot. The side slot holds one value bit and one occupancy bit. Results equal to 0 or 1 can be parked in the side slot instead of the full word. The full word can then go straight back to the free list in the same cycle, while consumers keep the tag they were renamed with. No consumer tag is ever rewritten.

Renaming hands out tags one bit wider than the register index. When a free index is taken, the extra top bit is set if that entry's side slot is already occupied. A set top bit pins every later write and read through that tag to the full word. A clear top bit lets a write choose the side slot, and lets a read follow the side slot whenever it is occupied.

The block has two read ports and one write port, and a write is forwarded to reads in the same cycle. Side slots have no allocator of their own: a release input simply marks a slot empty.

Top module: `erf_top`

## Requirements
- R1: After reset every side slot is empty and every full word reads as zero.
- R2: When a write is placed in a side slot, `freeValid` is 1 in that same cycle, combinationally, and `freeTag` equals the low TAG_W bits of `wrTag`. In every other cycle `freeValid` is 0.
- R3: `renTag` is `{occupied(allocTag), allocTag}`, where occupied is the side-slot occupancy as registered at the last clock edge.
- R4: A write with `wrTag[TAG_W]`=0, `wrData` of 0 or 1, and an empty side slot at that index does three things. It stores `wrData[0]` in the side slot, marks the slot occupied, and leaves the full word unchanged.
- R5: Any other write stores `wrData` in the full word and leaves the side slot untouched. This covers a set top bit, data above 1, or an occupied slot.
- R6: A read tag with the top bit set returns the full word. A read tag with the top bit clear returns the side slot if it is occupied, and the full word otherwise.
- R7: A side-slot read returns the stored bit zero-extended to DATA_W bits.
- R8: A write is visible on both read ports in the cycle it is presented, and follows the same steering as R6 applied to the state after the write.
- R9: A release marks a side slot empty at the next edge and keeps the full word and the stored bit. If a side-slot write hits the same index in the same cycle, the write wins and the slot stays occupied.
- R10: While a side slot is occupied, its index may be re-allocated with the top bit set and written. The slot's value stays readable through top-bit-clear tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocTag | input | TAG_W | Free index offered by the free list |
| renTag | output | TAG_W+1 | Steering tag for that index |
| wrEn | input | 1 | Write strobe |
| wrTag | input | TAG_W+1 | Steering tag of the result |
| wrData | input | DATA_W | Result value |
| freeValid | output | 1 | Full word returned to the free list this cycle |
| freeTag | output | TAG_W | Index being returned |
| relEn | input | 1 | Release strobe for a side slot |
| relIdx | input | TAG_W | Side slot to release |
| rdTagA | input | TAG_W+1 | Read port A tag |
| rdDataA | output | DATA_W | Read port A data |
| rdTagB | input | TAG_W+1 | Read port B tag |
| rdDataB | output | DATA_W | Read port B data |

## Verification
A wrong occupancy bit shows at the ports one cycle after the write or release that caused it. It appears in two places: the top bit of `renTag` for that index, and which value a top-bit-clear read returns. A missed full-word write or a wrongly steered result shows on the next read of that index, or at once on the forwarding path. A misjudged steering decision shows on `freeValid` in the write cycle itself. The bench keeps its own copy of words, slot bits and occupancy. It checks every port on every cycle, so each such fault is caught in the cycle it first becomes visible.

// File: rtl/erf_pkg.sv
package erf_pkg;
  typedef struct packed {
    logic wrReg;   // store result in the full word
    logic wrExt;   // store result bit in the side slot
    logic extBit;  // bit to store in the side slot
    logic relClr;  // clear side-slot occupancy
  } erfStrobes_t;
endpackage

// File: rtl/erf_ctrl.sv
module erf_ctrl
  import erf_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic                  wrEn,
  input  logic [TAG_W:0]        wrTag,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  relEn,
  input  logic [(1<<TAG_W)-1:0] extValidVec,
  output erfStrobes_t           strobes,
  output logic                  freeValid,
  output logic [TAG_W-1:0]      freeTag
);
  localparam int IDX_MSB = TAG_W - 1;

  logic [IDX_MSB:0] wrIdx;
  logic             smallVal;
  logic             slotEmpty;
  logic             toExt;

  always_comb begin
    wrIdx     = wrTag[IDX_MSB:0];
    smallVal  = (wrData[DATA_W-1:1] == '0);
    slotEmpty = !extValidVec[wrIdx];
    toExt     = wrEn && !wrTag[TAG_W] && smallVal && slotEmpty;

    strobes.wrExt  = toExt;
    strobes.wrReg  = wrEn && !toExt;
    strobes.extBit = wrData[0];
    strobes.relClr = relEn;

    freeValid = toExt;
    freeTag   = wrIdx;
  end
endmodule

// File: rtl/erf_datapath.sv
module erf_datapath
  import erf_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 64,
  parameter int NRD    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  erfStrobes_t                   strobes,
  input  logic [TAG_W:0]                wrTag,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [TAG_W-1:0]              relIdx,
  input  logic [TAG_W-1:0]              allocTag,
  output logic [TAG_W:0]                renTag,
  input  logic [NRD-1:0][TAG_W:0]       rdTags,
  output logic [NRD-1:0][DATA_W-1:0]    rdData,
  output logic [(1<<TAG_W)-1:0]         extValidVec
);
  localparam int NREG = 1 << TAG_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic [NREG-1:0]   extValid;
  logic [NREG-1:0]   extValue;
  logic [TAG_W-1:0]  wrIdx;

  assign wrIdx       = wrTag[TAG_W-1:0];
  assign extValidVec = extValid;
  assign renTag      = {extValid[allocTag], allocTag};

  // full words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (strobes.wrReg) begin
      regFile[wrIdx] <= wrData;
    end
  end

  // side slots: a same-cycle slot write beats a release
  for (genvar g = 0; g < NREG; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        extValid[g] <= 1'b0;
        extValue[g] <= 1'b0;
      end else if (strobes.wrExt && wrIdx == TAG_W'(g)) begin
        extValid[g] <= 1'b1;
        extValue[g] <= strobes.extBit;
      end else if (strobes.relClr && relIdx == TAG_W'(g)) begin
        extValid[g] <= 1'b0;
      end
    end
  end

  // read ports with forwarding of the current write
  for (genvar p = 0; p < NRD; p++) begin : gRd
    logic [TAG_W-1:0]  idx;
    logic              hit;
    logic              slotOcc;
    logic              slotBit;
    logic [DATA_W-1:0] wordVal;
    always_comb begin
      idx     = rdTags[p][TAG_W-1:0];
      hit     = (idx == wrIdx);
      slotOcc = extValid[idx] | (strobes.wrExt & hit);
      slotBit = (strobes.wrExt && hit) ? strobes.extBit : extValue[idx];
      wordVal = (strobes.wrReg && hit) ? wrData : regFile[idx];
      if (!rdTags[p][TAG_W] && slotOcc)
        rdData[p] = {{(DATA_W-1){1'b0}}, slotBit};
      else
        rdData[p] = wordVal;
    end
  end
endmodule

// File: rtl/erf_top.sv
module erf_top
  import erf_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  allocTag,
  output logic [TAG_W:0]    renTag,
  input  logic              wrEn,
  input  logic [TAG_W:0]    wrTag,
  input  logic [DATA_W-1:0] wrData,
  output logic              freeValid,
  output logic [TAG_W-1:0]  freeTag,
  input  logic              relEn,
  input  logic [TAG_W-1:0]  relIdx,
  input  logic [TAG_W:0]    rdTagA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [TAG_W:0]    rdTagB,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int NRD = 2;

  erfStrobes_t                strobes;
  logic [(1<<TAG_W)-1:0]      extValidVec;
  logic [NRD-1:0][TAG_W:0]    rdTags;
  logic [NRD-1:0][DATA_W-1:0] rdData;

  assign rdTags[0] = rdTagA;
  assign rdTags[1] = rdTagB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  erf_ctrl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .wrEn(wrEn), .wrTag(wrTag), .wrData(wrData), .relEn(relEn),
    .extValidVec(extValidVec), .strobes(strobes),
    .freeValid(freeValid), .freeTag(freeTag)
  );

  erf_datapath #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NRD(NRD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrTag(wrTag), .wrData(wrData),
    .relIdx(relIdx), .allocTag(allocTag), .renTag(renTag),
    .rdTags(rdTags), .rdData(rdData), .extValidVec(extValidVec)
  );
endmodule

// File: rtl/erf_checker.sv
module erf_checker #(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [TAG_W:0]        wrTag,
  input logic [DATA_W-1:0]     wrData,
  input logic                  relEn,
  input logic [TAG_W-1:0]      relIdx,
  input logic                  freeValid,
  input logic [TAG_W-1:0]      freeTag,
  input logic [TAG_W:0]        rdTagA,
  input logic [DATA_W-1:0]     rdDataA,
  input logic [(1<<TAG_W)-1:0] extValidVec
);
  assert_free_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> (wrEn && !wrTag[TAG_W] && freeTag == wrTag[TAG_W-1:0]
                   && wrData[DATA_W-1:1] == '0));

  assert_slot_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrTag[TAG_W] && wrData[DATA_W-1:1] == '0
     && !extValidVec[wrTag[TAG_W-1:0]])
    |=> extValidVec[$past(wrTag[TAG_W-1:0])]);

  assert_slot_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrTag[TAG_W] && !relEn) |=> (extValidVec == $past(extValidVec)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (relEn && !(freeValid && freeTag == relIdx)) |=> !extValidVec[$past(relIdx)]);

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdTagA[TAG_W] && extValidVec[rdTagA[TAG_W-1:0]])
    |-> (rdDataA[DATA_W-1:1] == '0));
endmodule

bind erf_top erf_checker #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTag(wrTag), .wrData(wrData),
  .relEn(relEn), .relIdx(relIdx), .freeValid(freeValid), .freeTag(freeTag),
  .rdTagA(rdTagA), .rdDataA(rdDataA), .extValidVec(extValidVec)
);

// File: tb/erf_top_bench.sv
module erf_top_bench;
  localparam int TW = 5;
  localparam int DW = 64;
  localparam int NR = 1 << TW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] allocTag = '0;
  logic [TW:0]   renTag;
  logic          wrEn = 1'b0;
  logic [TW:0]   wrTag = '0;
  logic [DW-1:0] wrData = '0;
  logic          freeValid;
  logic [TW-1:0] freeTag;
  logic          relEn = 1'b0;
  logic [TW-1:0] relIdx = '0;
  logic [TW:0]   rdTagA = '0, rdTagB = '0;
  logic [DW-1:0] rdDataA, rdDataB;

  int nChk = 0, nBad = 0;
  bit done = 0;

  logic [DW-1:0] mReg [NR];
  logic          mOcc [NR];
  logic          mBit [NR];

  always #4 clk = ~clk;

  erf_top #(.TAG_W(TW), .DATA_W(DW)) u_erf_top (.*);

  task automatic chk(input string lbl, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", lbl, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expRead(input logic [TW:0] t, input logic we,
      input logic toExt, input logic [TW:0] wt, input logic [DW-1:0] wd);
    logic [TW-1:0] i = t[TW-1:0];
    logic hit = we && (wt[TW-1:0] == i);
    logic occ = mOcc[i] || (toExt && hit);
    logic b   = (toExt && hit) ? wd[0] : mBit[i];
    logic [DW-1:0] w = (hit && !toExt) ? wd : mReg[i];
    return (!t[TW] && occ) ? {{(DW-1){1'b0}}, b} : w;
  endfunction

  task automatic step(input string lbl, input logic we, input logic [TW:0] wt,
      input logic [DW-1:0] wd, input logic re, input logic [TW-1:0] ri,
      input logic [TW-1:0] at, input logic [TW:0] ta, input logic [TW:0] tb);
    logic toExt;
    @(negedge clk);
    wrEn = we; wrTag = wt; wrData = wd; relEn = re; relIdx = ri;
    allocTag = at; rdTagA = ta; rdTagB = tb;
    #2;
    toExt = we && !wt[TW] && (wd[DW-1:1] == '0) && !mOcc[wt[TW-1:0]];
    chk(lbl, "freeValid", DW'(freeValid), DW'(toExt));
    if (toExt) chk(lbl, "freeTag", DW'(freeTag), DW'(wt[TW-1:0]));
    chk(lbl, "renTag", DW'(renTag), DW'({mOcc[at], at}));
    chk(lbl, "rdDataA", rdDataA, expRead(ta, we, toExt, wt, wd));
    chk(lbl, "rdDataB", rdDataB, expRead(tb, we, toExt, wt, wd));
    @(posedge clk);
    if (re) mOcc[ri] = 1'b0;
    if (toExt) begin mOcc[wt[TW-1:0]] = 1'b1; mBit[wt[TW-1:0]] = wd[0]; end
    else if (we) mReg[wt[TW-1:0]] = wd;
  endtask

  task automatic idle(input string lbl, input logic [TW-1:0] at,
                      input logic [TW:0] ta, input logic [TW:0] tb);
    step(lbl, 1'b0, '0, '0, 1'b0, '0, at, ta, tb);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin mReg[i] = '0; mOcc[i] = 0; mBit[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state on both tag flavours
    idle("R1", 5'd3, 6'b0_00011, 6'b1_00011);
    idle("R1", 5'd31, 6'b0_11111, 6'b1_00000);

    // R4, R2, R8: small value to empty slot, read back in the same cycle
    step("R4 R8", 1, 6'b0_00101, 64'd1, 0, '0, 5'd5, 6'b0_00101, 6'b1_00101);
    // R3: index now carries top bit set; R6 reads
    idle("R3 R6", 5'd5, 6'b0_00101, 6'b1_00101);
    // R10, R5: re-allocated with top bit set, full word written, slot kept
    step("R10 R5", 1, 6'b1_00101, 64'h0123_4567_89ab_cdef, 0, '0, 5'd5,
         6'b0_00101, 6'b1_00101);
    idle("R10", 5'd5, 6'b0_00101, 6'b1_00101);
    // R5: small value but slot busy goes to the full word, no free pulse
    step("R5", 1, 6'b0_00101, 64'd0, 0, '0, 5'd5, 6'b1_00101, 6'b0_00101);
    // R5: value 2 is not small
    step("R5", 1, 6'b0_00110, 64'd2, 0, '0, 5'd6, 6'b0_00110, 6'b1_00110);
    // R7: zero-extension of a 0 bit in a slot
    step("R7", 1, 6'b0_00111, 64'd0, 0, '0, 5'd7, 6'b0_00111, 6'b0_00111);
    // R9: release, then full word visible and top bit clear on rename
    step("R9", 0, '0, '0, 1, 5'd5, 5'd5, 6'b0_00101, 6'b1_00101);
    idle("R9", 5'd5, 6'b0_00101, 6'b1_00101);
    // R9: release and slot write to same index, write wins
    step("R9", 1, 6'b0_01000, 64'd1, 1, 5'd8, 5'd8, 6'b0_01000, 6'b0_01000);
    idle("R9", 5'd8, 6'b0_01000, 6'b1_01000);

    // random mix covering R2 R3 R4 R5 R6 R7 R8 R9 R10
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [TW:0]   wt = TW'($urandom);
      logic [DW-1:0] wd;
      logic [TW-1:0] hot = TW'($urandom_range(0, 3));
      int sel = $urandom_range(0, 9);
      wt[TW-1:0] = ($urandom_range(0, 1) != 0) ? hot : TW'($urandom);
      wt[TW] = ($urandom_range(0, 2) == 0);
      wd = (sel < 4) ? DW'(0) : (sel < 7) ? DW'(1) : (sel < 8) ? DW'(2)
           : {32'($urandom), 32'($urandom)};
      step("R4/R5/R6/R8 random", ($urandom_range(0, 3) != 0), wt, wd,
           ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 1) != 0) ? hot : TW'($urandom),
           ($urandom_range(0, 1) != 0) ? hot : TW'($urandom),
           {1'($urandom), ($urandom_range(0, 1) != 0) ? hot : TW'($urandom)},
           {1'($urandom), ($urandom_range(0, 1) != 0) ? hot : TW'($urandom)});
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule